// File: doc/BRIEF.md
# I2C Mode and Status Register Controller

This block keeps the eight-bit mode and status register of an I2C bus interface. Software writes to the register. A separate bus engine reports bus events as one-cycle strobes: START seen, STOP seen, arbitration lost, byte finished, own address matched, R/W bit received, ACK missing and general call. The engine also supplies a level for the last received data bit. The block merges both sources each cycle. When a hardware condition and a software write touch the same bit in the same cycle, the hardware condition decides the result.

The two top bits select the operating mode. Software asks for a START by writing ones to the master, direction and bus-busy bits in one write. A guard window opens when a START appears on the bus and closes once the slave-address byte has been received. During that window, any write that tries to raise the master or direction bit is refused, and both bits are forced low. This covers the case where another master takes the bus just after software checked that it was free. When arbitration is lost, the master bit is not dropped at once. It falls when the current byte ends.

Top module: `i2c_mode_status_ctrl`

## Requirements
- R1: After reset the register reads 0x10: only the SCL-release bit is 1.
- R2: The register bits, MSB first, are master (b7), direction (b6), bus busy (b5), SCL release (b4), arbitration lost (b3), address match (b2), general call (b1) and last received bit (b0). `mode_o` = {b7,b6}: 0 slave receive, 1 slave transmit, 2 master receive, 3 master transmit.
- R3: A write with b7, b6 and b5 all 1 is a START request. When the guard is closed and no START strobe arrives in that cycle, the request sets master, direction and bus busy on the next cycle.
- R4: The guard window opens on a START strobe and closes on the next byte-done or STOP strobe. A write with b7 or b6 set, made while the window is open or in the same cycle as a START strobe, clears both master and direction. Bus busy is left as it was.
- R5: A START strobe sets bus busy and a STOP strobe clears it. If both arrive together, STOP wins. A write that is not an accepted START request leaves bus busy unchanged.
- R6: The hardware sets direction to 1 when all three hold: the address-mode select input is 0, master is 0, and an R/W strobe arrives carrying 1.
- R7: Direction clears on any of these: arbitration lost; STOP; START while master is 0; ACK missing while master is 0. The clear wins over a software write or a hardware set in the same cycle.
- R8: STOP clears master. After arbitration is lost, master stays 1 until the next byte-done strobe and clears on the cycle after it.
- R9: Software writes never change b3..b0.
- R10: Arbitration lost sets b3 and START clears it. Address match sets b2 and general call sets b1; START or STOP clears both. On a byte-done strobe, b0 loads the last-bit input. When a set and a clear arrive together, the clear wins.
- R11: Software writes b4. A byte-done strobe clears b4 to 0, which holds SCL low, and this wins over a write in the same cycle.
- R12: `rd_data_o` shows the register while `rd_en_i` is 1 and reads 0 otherwise.
- R13: Outside the guard window, a write that is not a START request loads b7 and b6 directly from the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| rd_en_i | input | 1 | Software read enable |
| rd_data_o | output | 8 | Read data |
| start_det_i | input | 1 | START seen on bus |
| stop_det_i | input | 1 | STOP seen on bus |
| arb_lost_i | input | 1 | Arbitration lost |
| byte_done_i | input | 1 | Byte transfer finished |
| addr_match_i | input | 1 | Own slave address matched |
| rw_valid_i | input | 1 | R/W bit received |
| rw_bit_i | input | 1 | Value of the received R/W bit |
| ack_miss_i | input | 1 | ACK not returned |
| gen_call_i | input | 1 | General call address seen |
| last_bit_i | input | 1 | Last received data bit |
| als_i | input | 1 | Address-mode select (0 = addressed mode) |
| status_o | output | 8 | Register value |
| mode_o | output | 2 | Current mode {master, direction} |

## Verification
The hardest case to reach is a competing master's START arriving between software's bus-free check and its START request. The stimulus pulses the START strobe while the bus is idle. It then issues a START request in the following cycle, and a second request in the same cycle as the strobe. Both requests must be refused, and bus busy must stay as the hardware set it. The stimulus then closes the window with a byte-done strobe and shows that a mode write is accepted again. Deferred master loss is reached by raising arbitration lost and then waiting idle cycles before byte-done arrives.

// File: rtl/i2c_ms_pkg.sv
package i2c_ms_pkg;
  localparam int REG_W   = 8;
  localparam int MODE_W  = 2;
  localparam int B_MST   = 7;
  localparam int B_TRX   = 6;
  localparam int B_BB    = 5;
  localparam int B_PIN   = 4;
  localparam int B_AL    = 3;
  localparam int B_AAS   = 2;
  localparam int B_AD0   = 1;
  localparam int B_LRB   = 0;
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(1) << B_PIN;

  typedef enum logic [MODE_W-1:0] {
    MODE_SLV_RX = 2'd0,
    MODE_SLV_TX = 2'd1,
    MODE_MST_RX = 2'd2,
    MODE_MST_TX = 2'd3
  } ms_mode_e;
endpackage

// File: rtl/i2c_ms_guard.sv
module i2c_ms_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic byte_done_i,
  input  logic arb_lost_i,
  output logic guard_o,
  output logic al_fire_o
);
  logic guard_q, pend_q;

  // window: opened by START, closed by address byte end or STOP
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) guard_q <= 1'b0;
    else if (start_det_i) guard_q <= 1'b1;
    else if (byte_done_i || stop_det_i) guard_q <= 1'b0;
  end

  // deferred master drop after arbitration loss
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else pend_q <= !stop_det_i && (arb_lost_i || (pend_q && !byte_done_i));
  end

  assign guard_o   = guard_q;
  assign al_fire_o = pend_q && byte_done_i;
endmodule

// File: rtl/i2c_ms_mode.sv
module i2c_ms_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_mst_i,
  input  logic wr_trx_i,
  input  logic wr_bb_i,
  input  logic guard_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  input  logic al_fire_i,
  input  logic ack_miss_i,
  input  logic rw_valid_i,
  input  logic rw_bit_i,
  input  logic als_i,
  output logic mst_o,
  output logic trx_o,
  output logic bb_o,
  output logic reject_o
);
  logic mst_q, trx_q, bb_q;
  logic reject, wr_ok, start_req;
  logic mst_clr, trx_clr, trx_set;
  logic mst_d, trx_d, bb_d;

  assign reject    = wr_en_i && (wr_mst_i || wr_trx_i) && (guard_i || start_det_i);
  assign wr_ok     = wr_en_i && !reject;
  assign start_req = wr_ok && wr_mst_i && wr_trx_i && wr_bb_i;

  assign mst_clr = stop_det_i || al_fire_i || reject;
  assign trx_set = !als_i && !mst_q && rw_valid_i && rw_bit_i;
  assign trx_clr = arb_lost_i || stop_det_i || reject
                 || (!mst_q && (start_det_i || ack_miss_i));

  always_comb begin
    mst_d = mst_q;
    if (wr_ok)   mst_d = wr_mst_i;
    if (mst_clr) mst_d = 1'b0;

    trx_d = trx_q;
    if (wr_ok)   trx_d = wr_trx_i;
    if (trx_set) trx_d = 1'b1;
    if (trx_clr) trx_d = 1'b0;

    bb_d = bb_q;
    if (start_req || start_det_i) bb_d = 1'b1;
    if (stop_det_i)               bb_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mst_q <= 1'b0;
      trx_q <= 1'b0;
      bb_q  <= 1'b0;
    end else begin
      mst_q <= mst_d;
      trx_q <= trx_d;
      bb_q  <= bb_d;
    end
  end

  assign mst_o    = mst_q;
  assign trx_o    = trx_q;
  assign bb_o     = bb_q;
  assign reject_o = reject;
endmodule

// File: rtl/i2c_ms_flags.sv
module i2c_ms_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_pin_i,
  input  logic start_det_i,
  input  logic stop_det_i,
  input  logic arb_lost_i,
  input  logic addr_match_i,
  input  logic gen_call_i,
  input  logic byte_done_i,
  input  logic last_bit_i,
  output logic pin_o,
  output logic al_o,
  output logic aas_o,
  output logic ad0_o,
  output logic lrb_o
);
  logic pin_q, al_q, aas_q, ad0_q, lrb_q;
  logic frame_clr;

  assign frame_clr = start_det_i || stop_det_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b1;
      al_q  <= 1'b0;
      aas_q <= 1'b0;
      ad0_q <= 1'b0;
      lrb_q <= 1'b0;
    end else begin
      if (byte_done_i)  pin_q <= 1'b0;
      else if (wr_en_i) pin_q <= wr_pin_i;

      if (start_det_i)     al_q <= 1'b0;
      else if (arb_lost_i) al_q <= 1'b1;

      if (frame_clr)         aas_q <= 1'b0;
      else if (addr_match_i) aas_q <= 1'b1;

      if (frame_clr)       ad0_q <= 1'b0;
      else if (gen_call_i) ad0_q <= 1'b1;

      if (byte_done_i) lrb_q <= last_bit_i;
    end
  end

  assign pin_o = pin_q;
  assign al_o  = al_q;
  assign aas_o = aas_q;
  assign ad0_o = ad0_q;
  assign lrb_o = lrb_q;
endmodule

// File: rtl/i2c_mode_status_ctrl.sv
module i2c_mode_status_ctrl
  import i2c_ms_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             arb_lost_i,
  input  logic             byte_done_i,
  input  logic             addr_match_i,
  input  logic             rw_valid_i,
  input  logic             rw_bit_i,
  input  logic             ack_miss_i,
  input  logic             gen_call_i,
  input  logic             last_bit_i,
  input  logic             als_i,
  output logic [REG_W-1:0] status_o,
  output logic [MODE_W-1:0] mode_o
);
  logic guard_w, al_fire_w, reject_w;
  logic mst_w, trx_w, bb_w, pin_w, al_w, aas_w, ad0_w, lrb_w;
  logic [REG_W-1:0] reg_w;

  i2c_ms_guard u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .byte_done_i (byte_done_i),
    .arb_lost_i  (arb_lost_i),
    .guard_o     (guard_w),
    .al_fire_o   (al_fire_w)
  );

  i2c_ms_mode u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_mst_i    (wr_data_i[B_MST]),
    .wr_trx_i    (wr_data_i[B_TRX]),
    .wr_bb_i     (wr_data_i[B_BB]),
    .guard_i     (guard_w),
    .start_det_i (start_det_i),
    .stop_det_i  (stop_det_i),
    .arb_lost_i  (arb_lost_i),
    .al_fire_i   (al_fire_w),
    .ack_miss_i  (ack_miss_i),
    .rw_valid_i  (rw_valid_i),
    .rw_bit_i    (rw_bit_i),
    .als_i       (als_i),
    .mst_o       (mst_w),
    .trx_o       (trx_w),
    .bb_o        (bb_w),
    .reject_o    (reject_w)
  );

  i2c_ms_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_pin_i     (wr_data_i[B_PIN]),
    .start_det_i  (start_det_i),
    .stop_det_i   (stop_det_i),
    .arb_lost_i   (arb_lost_i),
    .addr_match_i (addr_match_i),
    .gen_call_i   (gen_call_i),
    .byte_done_i  (byte_done_i),
    .last_bit_i   (last_bit_i),
    .pin_o        (pin_w),
    .al_o         (al_w),
    .aas_o        (aas_w),
    .ad0_o        (ad0_w),
    .lrb_o        (lrb_w)
  );

  always_comb begin
    reg_w        = '0;
    reg_w[B_MST] = mst_w;
    reg_w[B_TRX] = trx_w;
    reg_w[B_BB]  = bb_w;
    reg_w[B_PIN] = pin_w;
    reg_w[B_AL]  = al_w;
    reg_w[B_AAS] = aas_w;
    reg_w[B_AD0] = ad0_w;
    reg_w[B_LRB] = lrb_w;
  end

  assign status_o  = reg_w;
  assign mode_o    = {mst_w, trx_w};
  assign rd_data_o = rd_en_i ? reg_w : '0;
endmodule

// File: rtl/i2c_ms_chk.sv
module i2c_ms_chk
  import i2c_ms_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             rd_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             start_det_i,
  input logic             stop_det_i,
  input logic             arb_lost_i,
  input logic             byte_done_i,
  input logic             addr_match_i,
  input logic             rw_valid_i,
  input logic             rw_bit_i,
  input logic             ack_miss_i,
  input logic             gen_call_i,
  input logic             als_i,
  input logic             guard_w,
  input logic [REG_W-1:0] status_o
);
  AST_STOP_DROPS_MST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> !status_o[B_MST] && !status_o[B_BB]) else $error("stop"); // R8

  AST_GUARD_REJECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[B_MST] || wr_data_i[B_TRX]) && guard_w)
    |=> !status_o[B_MST] && !status_o[B_TRX]) else $error("guard"); // R4

  AST_RO_LOW_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arb_lost_i && !addr_match_i && !gen_call_i && !start_det_i
     && !stop_det_i && !byte_done_i)
    |=> status_o[B_AL:B_LRB] == $past(status_o[B_AL:B_LRB])) else $error("ro"); // R9

  AST_TRX_HW_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!als_i && !status_o[B_MST] && rw_valid_i && rw_bit_i && !arb_lost_i
     && !stop_det_i && !start_det_i && !ack_miss_i && !guard_w && !wr_en_i)
    |=> status_o[B_TRX]) else $error("trx set"); // R6

  AST_BYTE_HOLDS_SCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> !status_o[B_PIN]) else $error("pin"); // R11

  AST_AL_DEFERS_MST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_i && status_o[B_MST] && !byte_done_i && !stop_det_i && !wr_en_i)
    |=> status_o[B_MST]) else $error("defer"); // R8

  always_comb begin
    if (rst_ni && !rd_en_i)
      AST_RD_GATED: assert (rd_data_o == '0) else $error("rd"); // R12
  end
endmodule

bind i2c_mode_status_ctrl i2c_ms_chk u_chk (.*);

// File: tb/sim_i2c_mode_status_ctrl.sv
module sim_i2c_mode_status_ctrl;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, rd_en = 0, st = 0, sp = 0, al = 0, bd = 0, am = 0;
  logic rwv = 0, rw = 0, ack = 0, gc = 0, lb = 0, als = 0;
  logic [7:0] wd = '0;
  logic [7:0] rd_data, status;
  logic [1:0] mode;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  logic [8:0] q_val[$];
  string      q_tag[$];

  // reference state
  logic m_mst = 0, m_trx = 0, m_bb = 0, m_pin = 1, m_al = 0, m_aas = 0;
  logic m_ad0 = 0, m_lrb = 0, m_guard = 0, m_pend = 0;

  always #4 clk = ~clk;

  i2c_mode_status_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wd),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .start_det_i(st), .stop_det_i(sp),
    .arb_lost_i(al), .byte_done_i(bd), .addr_match_i(am), .rw_valid_i(rwv),
    .rw_bit_i(rw), .ack_miss_i(ack), .gen_call_i(gc), .last_bit_i(lb),
    .als_i(als), .status_o(status), .mode_o(mode)
  );

  function automatic logic [7:0] m_reg();
    return {m_mst, m_trx, m_bb, m_pin, m_al, m_aas, m_ad0, m_lrb};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic i_we = 0, logic [7:0] i_wd = 0,
                      logic i_st = 0, logic i_sp = 0, logic i_al = 0,
                      logic i_bd = 0, logic i_am = 0, logic i_rwv = 0,
                      logic i_rw = 0, logic i_ack = 0, logic i_gc = 0,
                      logic i_lb = 0, logic i_als = 0, logic i_rd = 0);
    logic rej, wok, sreq, fire;
    logic n_mst, n_trx, n_bb, n_pin, n_al, n_aas, n_ad0, n_lrb, n_guard;
    @(negedge clk);
    wr_en = i_we; wd = i_wd; st = i_st; sp = i_sp; al = i_al; bd = i_bd;
    am = i_am; rwv = i_rwv; rw = i_rw; ack = i_ack; gc = i_gc; lb = i_lb;
    als = i_als; rd_en = i_rd;
    rej  = i_we && (i_wd[7] || i_wd[6]) && (m_guard || i_st);
    wok  = i_we && !rej;
    sreq = wok && i_wd[7] && i_wd[6] && i_wd[5];
    fire = m_pend && i_bd;
    n_mst = m_mst;
    if (wok) n_mst = i_wd[7];
    if (i_sp || fire || rej) n_mst = 0;
    n_trx = m_trx;
    if (wok) n_trx = i_wd[6];
    if (!i_als && !m_mst && i_rwv && i_rw) n_trx = 1;
    if (i_al || i_sp || rej || (!m_mst && (i_st || i_ack))) n_trx = 0;
    n_bb = m_bb;
    if (sreq || i_st) n_bb = 1;
    if (i_sp) n_bb = 0;
    n_pin = i_bd ? 1'b0 : (i_we ? i_wd[4] : m_pin);
    n_al  = i_st ? 1'b0 : (i_al ? 1'b1 : m_al);
    n_aas = (i_st || i_sp) ? 1'b0 : (i_am ? 1'b1 : m_aas);
    n_ad0 = (i_st || i_sp) ? 1'b0 : (i_gc ? 1'b1 : m_ad0);
    n_lrb = i_bd ? i_lb : m_lrb;
    n_guard = i_st ? 1'b1 : ((i_bd || i_sp) ? 1'b0 : m_guard);
    m_pend = !i_sp && (i_al || (m_pend && !i_bd));
    m_mst = n_mst; m_trx = n_trx; m_bb = n_bb; m_pin = n_pin; m_al = n_al;
    m_aas = n_aas; m_ad0 = n_ad0; m_lrb = n_lrb; m_guard = n_guard;
    q_val.push_back({i_rd, m_reg()});
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n, string tag = "idle");
    for (int i = 0; i < n; i++) step(tag);
  endtask

  // monitor: compare after each edge, away from it
  always @(posedge clk) begin
    #2;
    if (rst_ni && q_val.size() > 0) begin
      logic [8:0] e;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      check(t, status, e[7:0]);
      check("R2 mode", {6'b0, mode}, {6'b0, e[7:6]});
      check("R12 read", rd_data, e[8] ? e[7:0] : 8'h00);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1 check("R1 reset", status, 8'h10);
    // R13 plain mode writes
    step("R13", .i_we(1), .i_wd(8'h90));
    step("R13", .i_we(1), .i_wd(8'h50), .i_rd(1));
    step("R13", .i_we(1), .i_wd(8'h10));
    // R3 START request, then STOP
    step("R3", .i_we(1), .i_wd(8'hF0));
    idle(1, "R3");
    step("R8 stop", .i_sp(1));
    // R4 foreign START then request inside window
    step("R5 start", .i_st(1));
    step("R4 reject", .i_we(1), .i_wd(8'hF0), .i_rd(1));
    step("R4 reject", .i_we(1), .i_wd(8'h40));
    step("R4 close", .i_bd(1), .i_lb(1));
    step("R13 reopen", .i_we(1), .i_wd(8'hD0));
    step("R5 stop", .i_sp(1));
    step("R4 same", .i_we(1), .i_wd(8'hF0), .i_st(1));
    step("R5 both", .i_st(1), .i_sp(1));
    // R6 hardware direction set
    step("R6", .i_rwv(1), .i_rw(1));
    step("R7 ack", .i_ack(1));
    step("R6 als", .i_rwv(1), .i_rw(1), .i_als(1));
    step("R6 rw0", .i_rwv(1), .i_rw(0));
    // R7 clears beat writes
    step("R13", .i_we(1), .i_wd(8'h40));
    step("R7 al", .i_we(1), .i_wd(8'h50), .i_al(1));
    step("R7 sp", .i_we(1), .i_wd(8'h50), .i_sp(1));
    step("R7", .i_we(1), .i_wd(8'hD0));
    step("R7 ackm", .i_ack(1));
    step("R7 stm", .i_rwv(1), .i_rw(1));
    // R8 deferred master drop
    step("R8 al", .i_al(1));
    idle(3, "R8 hold");
    step("R8 bd", .i_bd(1));
    idle(1, "R8");
    // R9/R10 read-only flags
    step("R10 am", .i_am(1), .i_gc(1));
    step("R10 lrb", .i_bd(1), .i_lb(1));
    step("R9", .i_we(1), .i_wd(8'h10), .i_rd(1));
    step("R9", .i_we(1), .i_wd(8'h1F));
    step("R9", .i_we(1), .i_wd(8'h00));
    step("R10 al", .i_al(1), .i_am(1), .i_st(1));
    step("R10 sp", .i_sp(1), .i_gc(1));
    step("R10 lrb0", .i_bd(1), .i_lb(0));
    // R11 SCL release bit
    step("R11", .i_we(1), .i_wd(8'h10));
    step("R11 bd", .i_we(1), .i_wd(8'h10), .i_bd(1));
    step("R11", .i_we(1), .i_wd(8'h10), .i_rd(1));
    idle(3);
    repeat (2) @(negedge clk);
    if (q_val.size() != 0) begin
      mismatched++;
      $display("FAIL queue: actual %0d expected 0", q_val.size());
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule